// File: doc/BRIEF.md
# Transmit Data-Valid Cadence Generator

This block produces the strobe that tells a serial digital video transmitter which clock cycles of its parallel pixel clock carry a new data word. The spacing of these strobes depends on the video standard being sent. Standard-definition uses an irregular eleven-cycle rhythm. High-definition alternates or stays high, depending on whether the surrounding core is built for one rate or for several. Every faster standard takes a word on every cycle.

The block decodes a 3-bit standard selection code each cycle. A phase counter steps through the rhythm of the decoded standard, and the strobe is driven from a register. When the code changes, the phase counter is forced back to the start. The first cycle under the new code is therefore always a valid cycle, and the transmitter never sees a truncated or spliced pattern. The single-rate or multi-rate build is picked by a parameter at elaboration.

Top module: `sdi_tx_valid_cadence`

## Requirements
- R1: While `rst_n` is low, `tx_valid` is 0. Asserting `rst_n` forces it to 0 at once, with no clock edge needed.
- R2: Codes 3'b011 and 3'b010 (3G, two mappings), 3'b101 and 3'b100 (6G, 4 and 8 streams), and 3'b111 and 3'b110 (12G, 8 and 16 streams) all select the continuous-high rhythm. Code 3'b000 selects the standard-definition rhythm. Code 3'b001 selects the high-definition rhythm.
- R3: Under code 3'b000, the outputs after successive clock edges form the 11-cycle loop 1,0,0,0,0,1,0,0,0,0,0, beginning at a restart.
- R4: With `SINGLE_RATE` = 0, code 3'b001 gives the 2-cycle loop 1,0, beginning at a restart.
- R5: With `SINGLE_RATE` = 1, code 3'b001 keeps `tx_valid` at 1 after every clock edge.
- R6: Every code named as continuous-high in R2 keeps `tx_valid` at 1 after every clock edge.
- R7: After any clock edge where `std_sel` differs from its value at the previous edge, `tx_valid` is 1, and the new code's loop continues from its second position.
- R8: After the first clock edge following reset release, `tx_valid` is 1, and the loop of the current code runs from its first position.
- R9: While `std_sel` stays unchanged, the loop is not restarted. It wraps only at its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronously to `clk` |
| std_sel | input | 3 | Requested video standard code |
| tx_valid | output | 1 | Registered data-valid strobe |

## Verification
A code change in the middle of the standard-definition loop is the sharpest corner. A design that failed to restart would continue the old phase, emit a low first cycle, or splice the two rhythms together. Changes between two codes that both run continuous-high must leave the output solid; a design that glitched low on restart would show a dropped cycle there. The run covers three full standard-definition periods so that a wrong wrap length, such as 10 or 12, shows up as a misplaced high. Reset is asserted in the middle of a high stretch to catch a reset that waits for the clock. The first edge after release is checked, because a design that counts from a stale phase would start low.

// File: rtl/sdi_cad_pkg.sv
package sdi_cad_pkg;

  // Rhythm class selected by the standard code
  typedef enum logic [1:0] {
    CAD_SD   = 2'd0,  // irregular 11-cycle loop
    CAD_ALT  = 2'd1,  // alternating high/low
    CAD_HIGH = 2'd2   // every cycle valid
  } cad_cls_e;

  localparam int unsigned STD_W = 3;

  localparam logic [STD_W-1:0] STD_CODE_SD = 3'b000;
  localparam logic [STD_W-1:0] STD_CODE_HD = 3'b001;

endpackage

// File: rtl/sdi_std_decode.sv
module sdi_std_decode
  import sdi_cad_pkg::*;
#(
  parameter bit SINGLE_RATE = 1'b0
) (
  input  logic [STD_W-1:0] std_code,
  output cad_cls_e         cls
);

  cad_cls_e hd_cls;

  // Build variant decides how high-definition is paced
  generate
    if (SINGLE_RATE) begin : g_hd_single
      assign hd_cls = CAD_HIGH;
    end else begin : g_hd_multi
      assign hd_cls = CAD_ALT;
    end
  endgenerate

  always_comb begin
    unique case (std_code)
      STD_CODE_SD: cls = CAD_SD;
      STD_CODE_HD: cls = hd_cls;
      default:     cls = CAD_HIGH;
    endcase
  end

endmodule

// File: rtl/sdi_std_track.sv
module sdi_std_track
  import sdi_cad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STD_W-1:0] std_code,
  output logic             restart
);

  logic             started_q, started_d;
  logic [STD_W-1:0] code_q, code_d;

  // Restart on the first active edge and on every code change
  assign restart = !started_q || (std_code != code_q);

  always_comb begin
    started_d = 1'b1;
    code_d    = std_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      code_q    <= '0;
    end else begin
      started_q <= started_d;
      code_q    <= code_d;
    end
  end

endmodule

// File: rtl/sdi_cad_phase.sv
module sdi_cad_phase
  import sdi_cad_pkg::*;
#(
  parameter int unsigned PH_W       = 4,
  parameter int unsigned SD_PERIOD  = 11,
  parameter int unsigned ALT_PERIOD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cad_cls_e        cls,
  input  logic            restart,
  output logic [PH_W-1:0] phase_nxt
);

  localparam logic [PH_W-1:0] SD_LAST  = PH_W'(SD_PERIOD - 1);
  localparam logic [PH_W-1:0] ALT_LAST = PH_W'(ALT_PERIOD - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last_ph;
  logic            cnt_en;

  always_comb begin
    unique case (cls)
      CAD_SD:  last_ph = SD_LAST;
      CAD_ALT: last_ph = ALT_LAST;
      default: last_ph = '0;
    endcase
  end

  // Counter only needs to move for rhythms with gaps, or to be cleared
  assign cnt_en = restart || (cls != CAD_HIGH);

  always_comb begin
    if (restart || (phase_q >= last_ph)) begin
      phase_nxt = '0;
    end else begin
      phase_nxt = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/sdi_cad_pattern.sv
module sdi_cad_pattern
  import sdi_cad_pkg::*;
#(
  parameter int unsigned PH_W      = 4,
  parameter int unsigned SD_HIGH_A = 1,
  parameter int unsigned SD_LOW_A  = 4,
  parameter int unsigned SD_HIGH_B = 1,
  parameter int unsigned ALT_HIGH  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cad_cls_e        cls,
  input  logic [PH_W-1:0] phase,
  output logic            valid
);

  localparam logic [PH_W-1:0] SD_A_END  = PH_W'(SD_HIGH_A);
  localparam logic [PH_W-1:0] SD_B_BEG  = PH_W'(SD_HIGH_A + SD_LOW_A);
  localparam logic [PH_W-1:0] SD_B_END  = PH_W'(SD_HIGH_A + SD_LOW_A + SD_HIGH_B);
  localparam logic [PH_W-1:0] ALT_END   = PH_W'(ALT_HIGH);

  logic valid_q, valid_d;

  always_comb begin
    unique case (cls)
      CAD_SD:  valid_d = (phase < SD_A_END) ||
                         ((phase >= SD_B_BEG) && (phase < SD_B_END));
      CAD_ALT: valid_d = (phase < ALT_END);
      default: valid_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;

endmodule

// File: rtl/sdi_tx_valid_cadence.sv
module sdi_tx_valid_cadence
  import sdi_cad_pkg::*;
#(
  parameter bit          SINGLE_RATE = 1'b0,
  parameter int unsigned SD_HIGH_A   = 1,
  parameter int unsigned SD_LOW_A    = 4,
  parameter int unsigned SD_HIGH_B   = 1,
  parameter int unsigned SD_LOW_B    = 5,
  parameter int unsigned ALT_HIGH    = 1,
  parameter int unsigned ALT_LOW     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STD_W-1:0] std_sel,
  output logic             tx_valid
);

  localparam int unsigned SD_PERIOD  = SD_HIGH_A + SD_LOW_A + SD_HIGH_B + SD_LOW_B;
  localparam int unsigned ALT_PERIOD = ALT_HIGH + ALT_LOW;
  localparam int unsigned PER_MAX    = (SD_PERIOD > ALT_PERIOD) ? SD_PERIOD : ALT_PERIOD;
  localparam int unsigned PH_W       = (PER_MAX > 2) ? $clog2(PER_MAX) : 1;

  cad_cls_e        cls;
  logic            restart;
  logic [PH_W-1:0] phase_nxt;

  sdi_std_decode #(
    .SINGLE_RATE (SINGLE_RATE)
  ) u_decode (
    .std_code (std_sel),
    .cls      (cls)
  );

  sdi_std_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .std_code (std_sel),
    .restart  (restart)
  );

  sdi_cad_phase #(
    .PH_W       (PH_W),
    .SD_PERIOD  (SD_PERIOD),
    .ALT_PERIOD (ALT_PERIOD)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls       (cls),
    .restart   (restart),
    .phase_nxt (phase_nxt)
  );

  sdi_cad_pattern #(
    .PH_W      (PH_W),
    .SD_HIGH_A (SD_HIGH_A),
    .SD_LOW_A  (SD_LOW_A),
    .SD_HIGH_B (SD_HIGH_B),
    .ALT_HIGH  (ALT_HIGH)
  ) u_pattern (
    .clk   (clk),
    .rst_n (rst_n),
    .cls   (cls),
    .phase (phase_nxt),
    .valid (tx_valid)
  );

endmodule

// File: rtl/sdi_tx_valid_cadence_chk.sv
module sdi_tx_valid_cadence_chk #(
  parameter bit          SINGLE_RATE = 1'b0,
  parameter int unsigned SD_HIGH_A   = 1,
  parameter int unsigned SD_HIGH_B   = 1,
  parameter int unsigned ALT_HIGH    = 1,
  parameter int unsigned ALT_LOW     = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] std_sel,
  input logic       tx_valid
);

  localparam bit SD_SINGLE_HIGHS = (SD_HIGH_A == 1) && (SD_HIGH_B == 1);
  localparam bit ALT_UNIT        = (ALT_HIGH == 1) && (ALT_LOW == 1);

  logic fast_code;
  assign fast_code = (std_sel[1] == 1'b1) || (std_sel[2] == 1'b1) ||
                     ((std_sel == 3'b001) && SINGLE_RATE);

  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (std_sel != $past(std_sel)) |=> tx_valid);  // R7

  AST_FAST_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
    fast_code |=> tx_valid);  // R6

  AST_HD_TOGGLE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!SINGLE_RATE && ALT_UNIT && std_sel == 3'b001 && $past(std_sel) == 3'b001 && tx_valid)
    |=> !tx_valid);  // R4

  AST_HD_TOGGLE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!SINGLE_RATE && ALT_UNIT && std_sel == 3'b001 && !tx_valid) |=> tx_valid);  // R4

  AST_SD_NO_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (SD_SINGLE_HIGHS && std_sel == 3'b000 && $past(std_sel) == 3'b000 && tx_valid)
    |=> !tx_valid);  // R3

endmodule

bind sdi_tx_valid_cadence sdi_tx_valid_cadence_chk #(
  .SINGLE_RATE (SINGLE_RATE),
  .SD_HIGH_A   (SD_HIGH_A),
  .SD_HIGH_B   (SD_HIGH_B),
  .ALT_HIGH    (ALT_HIGH),
  .ALT_LOW     (ALT_LOW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .std_sel  (std_sel),
  .tx_valid (tx_valid)
);

// File: tb/sim_sdi_tx_valid_cadence.sv
`timescale 1ns/1ps
module sim_sdi_tx_valid_cadence;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] std_sel = 3'b000;
  logic       v_multi;
  logic       v_single;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic  m;
    logic  s;
    string tag;
  } exp_t;

  exp_t q[$];

  // bench-side reference state
  bit         mdl_started = 1'b0;
  logic [2:0] mdl_prev = 3'b000;
  int         ph_m = 0;
  int         ph_s = 0;

  always #2 clk = ~clk;

  sdi_tx_valid_cadence #(.SINGLE_RATE(1'b0)) u0 (
    .clk (clk), .rst_n (rst_n), .std_sel (std_sel), .tx_valid (v_multi)
  );

  sdi_tx_valid_cadence #(.SINGLE_RATE(1'b1)) u1 (
    .clk (clk), .rst_n (rst_n), .std_sel (std_sel), .tx_valid (v_single)
  );

  function automatic int loop_len(input logic [2:0] c, input bit single);
    if (c == 3'b000) return 11;
    if (c == 3'b001 && !single) return 2;
    return 1;
  endfunction

  function automatic logic loop_val(input logic [2:0] c, input bit single, input int ph);
    if (c == 3'b000) return (ph == 0) || (ph == 5);
    if (c == 3'b001 && !single) return (ph == 0);
    return 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Driver: sets the code away from the active edge and queues the expected result
  task automatic drive(input logic [2:0] c, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      bit rs;
      exp_t e;
      @(negedge clk);
      if (!rst_n) rst_n = 1'b1;
      std_sel = c;
      rs = !mdl_started || (c != mdl_prev);
      ph_m = rs ? 0 : (ph_m + 1) % loop_len(c, 1'b0);
      ph_s = rs ? 0 : (ph_s + 1) % loop_len(c, 1'b1);
      mdl_started = 1'b1;
      mdl_prev = c;
      e.m = loop_val(c, 1'b0, ph_m);
      e.s = loop_val(c, 1'b1, ph_s);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares one queued item after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        check(v_multi,  e.m, {e.tag, " multi-rate"});
        check(v_single, e.s, {e.tag, " single-rate"});
      end
    end
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1: held in reset across several edges
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(v_multi,  1'b0, "R1 reset multi-rate");
    check(v_single, 1'b0, "R1 reset single-rate");

    // R8, R3, R9: first edge starts the loop; three full SD periods, no restarts
    drive(3'b000, 33, "R8 R3 R9 sd");
    // R4, R5, R7: switch to HD
    drive(3'b001, 8, "R4 R5 R7 hd");
    // R7: SD interrupted mid-loop, HD, then SD again from the start
    drive(3'b000, 7, "R7 R3 sd-partial");
    drive(3'b001, 3, "R7 R4 hd-short");
    drive(3'b000, 12, "R7 R3 sd-restart");
    // R2, R6, R7: every fast code, with changes between them
    drive(3'b011, 4, "R2 R6 R7 code011");
    drive(3'b010, 4, "R2 R6 R7 code010");
    drive(3'b101, 4, "R2 R6 R7 code101");
    drive(3'b100, 4, "R2 R6 R7 code100");
    drive(3'b111, 4, "R2 R6 R7 code111");
    drive(3'b110, 4, "R2 R6 R7 code110");
    // R7: fast code back to SD lands on the first high
    drive(3'b000, 6, "R7 R3 fast-to-sd");
    drive(3'b001, 5, "R7 R4 R5 sd-to-hd");
    drive(3'b111, 3, "R6 R7 hd-to-fast");
    drain();

    // R1: asynchronous reset while output is high
    @(posedge clk);
    #1;
    check(v_multi, 1'b1, "R6 pre-reset multi-rate");
    rst_n = 1'b0;
    #0.5;
    check(v_multi,  1'b0, "R1 async reset multi-rate");
    check(v_single, 1'b0, "R1 async reset single-rate");
    repeat (2) @(posedge clk);
    #1;
    check(v_multi, 1'b0, "R1 held reset multi-rate");
    mdl_started = 1'b0;

    // R8: restart after reset with the code left unchanged
    drive(3'b111, 2, "R8 R6 post-reset fast");
    drive(3'b000, 13, "R7 R3 post-reset sd");
    drain();

    summary();
    $finish;
  end

endmodule